// File: doc/BRIEF.md
# Linked-Descriptor Transfer Engine

This block is a single-channel DMA engine. It walks a chain of descriptors that software builds in memory. Each descriptor is four 32-bit words on a 16-byte boundary. Word 0 is frame control, holding the size, the count field, the error flags and the ownership flag. Word 1 is a flag word, which the engine fetches but does not use. Word 2 is the buffer address. Word 3 is the link: a marker pair, a direction bit, an end-of-frame interrupt enable and the next descriptor address.

For every descriptor that the engine owns, it reads the buffer one 32-bit word at a time and presents each word on a valid/ready output stream. It then writes frame control back with ownership returned to software, and follows the link. First/last markers group descriptors into frames. The descriptor that closes a frame gets the frame's descriptor count written back. Errors and frame ends are gathered in a status register that drives one interrupt line.

The controller has seven named states. IDLE leaves on start or continue (to FETCH). FETCH reads the four words in order and goes to CHECK, or to IDLE on a bus error. CHECK goes to IDLE when ownership is software's ("stall"), to WBACK on a marker or zero-size error, and otherwise to READ. READ goes to PUSH, or to WBACK on a bus error. PUSH goes back to READ, or to WBACK after the final word. WBACK goes to IDLE after an error and otherwise to NEXT. NEXT goes to FETCH in chain mode and otherwise to IDLE.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset the four registers read zero, `irq`, `mem_req` and `out_valid` are low.
- R2: Register index 0 is control: write bit 31 = start, bit 30 = continue, bit 29 = chain mode, bit 17 = failure interrupt enable, bit 16 = protocol-error interrupt enable; read bit 31 = busy. Index 1 is the first-descriptor address and index 2 is the read-only current-descriptor address. A start copies index 1, with bits [3:0] cleared, into index 2, and the engine then reads that address, +4, +8 and +12 in that order. Start and continue are ignored while busy.
- R3: An owned descriptor of S bytes (frame-control bits [15:0]) yields ceil(S/4) stream words. They are read from the buffer address and then at steps of +4, or -4 when link bit 2 is 1. A word is held stable while `out_ready` is low.
- R4: After the transfer, frame control is written back to the descriptor address with bit 31 (ownership) cleared and bits [15:0] and [28:22] unchanged.
- R5: A descriptor whose link bit 0 (last) is set gets bits [21:16] written with the number of descriptors in its frame, counted from the descriptor with link bit 1 (first) set. Other descriptors keep their original count field. A stall does not break the count.
- R6: Only after the write-back does the engine move the current address to link bits [31:4] followed by four zero bits. In chain mode it fetches there; without chain mode it goes idle there.
- R7: A fetched descriptor with bit 31 clear stops the engine with no data moved and no write-back. The current address is unchanged. A later continue refetches that descriptor.
- R8: Status bit 27 (end of frame) is set after a last-marked descriptor is written back without error, and only when its link bit 3 is set.
- R9: A zero size or an error response on a buffer read sets frame-control bit 30 in the write-back and status bit 30, and stops the engine at that descriptor. An error response on a fetch or write-back sets status bit 30 and stops the engine.
- R10: A first-marked descriptor inside an open frame, or a descriptor not marked first outside a frame, sets frame-control bit 29 in the write-back and status bit 29, moves no data and stops the engine.
- R11: Status bits are cleared by writing 1 to them at register index 3. `irq` = bit27 OR (bit30 AND enable17) OR (bit29 AND enable16).
- R12: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from when a request is raised until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted and completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| out_valid | output | 1 | Stream word valid |
| out_data | output | 32 | Stream word |
| out_ready | input | 1 | Stream sink ready |
| irq | output | 1 | Interrupt |

## Verification
The hardest case to reach is a stall in the middle of a frame. To reach it, the second descriptor of an open frame is left owned by software. The bench then hands it over in memory and resumes with continue. This shows that the frame count survives across the idle gap and that the current address was parked on the stalled descriptor. A sweep over memory latency, back-pressure pattern and step direction runs every transfer path through one three-descriptor frame. Its chain ends on a software-owned descriptor, so each run also ends in the stall path. Bus errors are provoked by placing buffers above the populated memory range.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int BYTE_SH    = 2;
    localparam int FC_SIZE_W  = 16;
    localparam int FC_CNT_W   = 6;
    localparam int FC_CNT_LO  = 16;
    localparam int FC_PERR    = 29;
    localparam int FC_DERR    = 30;
    localparam int FC_OWN     = 31;
    localparam int LK_LAST    = 0;
    localparam int LK_FIRST   = 1;
    localparam int LK_DEC     = 2;
    localparam int LK_EOFIE   = 3;
    localparam int CTL_START  = 31;
    localparam int CTL_CONT   = 30;
    localparam int CTL_CHAIN  = 29;
    localparam int CTL_IE_FAIL = 17;
    localparam int CTL_IE_PERR = 16;
    localparam int ST_EOF     = 27;
    localparam int ST_PERR    = 29;
    localparam int ST_DERR    = 30;
    localparam int REG_AW     = 2;
    localparam logic [REG_AW-1:0] REG_CTRL  = 2'd0;
    localparam logic [REG_AW-1:0] REG_FIRST = 2'd1;
    localparam logic [REG_AW-1:0] REG_CUR   = 2'd2;
    localparam logic [REG_AW-1:0] REG_STAT  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_PUSH, ST_WBACK, ST_NEXT
    } walk_state_t;
endpackage

// File: rtl/dwalk_cursor.sv
module dwalk_cursor import dwalk_pkg::*; #(
    parameter int AW     = WORD_W,
    parameter int SIZE_W = FC_SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              dec,
    input  logic [AW-1:0]     base,
    input  logic [SIZE_W-1:0] size,
    output logic [AW-1:0]     ptr,
    output logic              last
);
    localparam int LEN_W = SIZE_W - 1;
    localparam logic [AW-1:0] STEP = AW'(1) << BYTE_SH;

    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] words_in;

    // whole words covering the byte size
    assign words_in = LEN_W'(size[SIZE_W-1:BYTE_SH]) + LEN_W'(|size[BYTE_SH-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            left_q <= '0;
        end else if (load) begin
            ptr    <= base;
            left_q <= words_in;
        end else if (step) begin
            ptr    <= dec ? ptr - STEP : ptr + STEP;
            left_q <= left_q - LEN_W'(1);
        end
    end

    assign last = (left_q == LEN_W'(1));

    // a word is never consumed beyond the computed count
    assert_step_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (left_q != '0));
endmodule

// File: rtl/dwalk_regs.sv
module dwalk_regs import dwalk_pkg::*; #(
    parameter int AW = WORD_W,
    parameter int DW = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              busy,
    input  logic [AW-1:0]     cur_addr,
    input  logic              set_eof,
    input  logic              set_perr,
    input  logic              set_derr,
    output logic              start,
    output logic              cont,
    output logic              chain,
    output logic [AW-1:0]     first_addr,
    output logic              irq
);
    localparam int ALIGN_W = $clog2(DESC_WORDS) + BYTE_SH;

    logic [AW-1:0] first_q;
    logic          ie_fail_q, ie_perr_q;
    logic          eof_q, perr_q, derr_q;
    logic          ctl_wr, stat_wr;

    assign ctl_wr  = reg_we && (reg_addr == REG_CTRL);
    assign stat_wr = reg_we && (reg_addr == REG_STAT);
    assign start   = ctl_wr && reg_wdata[CTL_START] && !busy;
    assign cont    = ctl_wr && reg_wdata[CTL_CONT] && !reg_wdata[CTL_START] && !busy;
    assign first_addr = {first_q[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q   <= '0;
            chain     <= 1'b0;
            ie_fail_q <= 1'b0;
            ie_perr_q <= 1'b0;
            eof_q     <= 1'b0;
            perr_q    <= 1'b0;
            derr_q    <= 1'b0;
        end else begin
            if (ctl_wr) begin
                chain     <= reg_wdata[CTL_CHAIN];
                ie_fail_q <= reg_wdata[CTL_IE_FAIL];
                ie_perr_q <= reg_wdata[CTL_IE_PERR];
            end
            if (reg_we && (reg_addr == REG_FIRST))
                first_q <= reg_wdata[AW-1:0];
            eof_q  <= set_eof  | (eof_q  & ~(stat_wr & reg_wdata[ST_EOF]));
            perr_q <= set_perr | (perr_q & ~(stat_wr & reg_wdata[ST_PERR]));
            derr_q <= set_derr | (derr_q & ~(stat_wr & reg_wdata[ST_DERR]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CTL_START]   = busy;
                reg_rdata[CTL_CHAIN]   = chain;
                reg_rdata[CTL_IE_FAIL] = ie_fail_q;
                reg_rdata[CTL_IE_PERR] = ie_perr_q;
            end
            REG_FIRST: reg_rdata = DW'(first_q);
            REG_CUR:   reg_rdata = DW'(cur_addr);
            REG_STAT: begin
                reg_rdata[ST_EOF]  = eof_q;
                reg_rdata[ST_PERR] = perr_q;
                reg_rdata[ST_DERR] = derr_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign irq = eof_q | (derr_q & ie_fail_q) | (perr_q & ie_perr_q);

    assert_w1c_eof_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[ST_EOF] && !set_eof) |=> !eof_q);
endmodule

// File: rtl/dwalk_seq.sv
module dwalk_seq import dwalk_pkg::*; #(
    parameter int AW     = WORD_W,
    parameter int DW     = WORD_W,
    parameter int SIZE_W = FC_SIZE_W,
    parameter int CNT_W  = FC_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cont,
    input  logic          chain,
    input  logic [AW-1:0] first_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic          set_eof,
    output logic          set_perr,
    output logic          set_derr
);
    localparam int IDX_W   = $clog2(DESC_WORDS);
    localparam int ALIGN_W = IDX_W + BYTE_SH;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

    walk_state_t state_q, state_d;

    logic [AW-1:0]    cur_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    fc_q, buf_q, link_q, data_q;
    logic             frame_open_q, derr_q, perr_q;
    logic [CNT_W-1:0] fcnt_q;

    logic             owned, mk_first, mk_last, size_zero, seq_bad, fail_any;
    logic [AW-1:0]    next_desc, buf_ptr;
    logic [DW-1:0]    wb_word;
    logic             buf_last, cur_load, cur_step;

    assign owned     = fc_q[FC_OWN];
    assign mk_first  = link_q[LK_FIRST];
    assign mk_last   = link_q[LK_LAST];
    assign size_zero = (fc_q[SIZE_W-1:0] == '0);
    assign seq_bad   = mk_first ? frame_open_q : !frame_open_q;
    assign fail_any  = derr_q | perr_q;
    assign next_desc = {link_q[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};

    // returned frame-control word: ownership back to software
    always_comb begin
        wb_word          = fc_q;
        wb_word[FC_OWN]  = 1'b0;
        wb_word[FC_DERR] = derr_q;
        wb_word[FC_PERR] = perr_q;
        if (mk_last && !fail_any)
            wb_word[FC_CNT_LO +: CNT_W] = fcnt_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start || cont) state_d = ST_FETCH;
            ST_FETCH: if (mem_ack) begin
                          if (mem_err)              state_d = ST_IDLE;
                          else if (idx_q == IDX_LAST) state_d = ST_CHECK;
                      end
            ST_CHECK: if (!owned)                   state_d = ST_IDLE;
                      else if (seq_bad || size_zero) state_d = ST_WBACK;
                      else                          state_d = ST_READ;
            ST_READ:  if (mem_ack) state_d = mem_err ? ST_WBACK : ST_PUSH;
            ST_PUSH:  if (out_ready) state_d = buf_last ? ST_WBACK : ST_READ;
            ST_WBACK: if (mem_ack) state_d = (mem_err || fail_any) ? ST_IDLE : ST_NEXT;
            ST_NEXT:  state_d = chain ? ST_FETCH : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // descriptor and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= '0;
            idx_q        <= '0;
            fc_q         <= '0;
            buf_q        <= '0;
            link_q       <= '0;
            data_q       <= '0;
            frame_open_q <= 1'b0;
            fcnt_q       <= '0;
            derr_q       <= 1'b0;
            perr_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_q        <= first_addr;
                        frame_open_q <= 1'b0;
                        fcnt_q       <= '0;
                    end
                    if (start || cont) begin
                        idx_q  <= '0;
                        derr_q <= 1'b0;
                        perr_q <= 1'b0;
                    end
                end
                ST_FETCH: if (mem_ack) begin
                    if (mem_err) begin
                        frame_open_q <= 1'b0;
                    end else begin
                        case (idx_q)
                            IDX_W'(0): fc_q   <= mem_rdata;
                            IDX_W'(2): buf_q  <= mem_rdata;
                            IDX_W'(3): link_q <= mem_rdata;
                            default: ;
                        endcase
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_CHECK: if (owned) begin
                    if (seq_bad) begin
                        perr_q <= 1'b1;
                    end else if (size_zero) begin
                        derr_q <= 1'b1;
                    end else begin
                        frame_open_q <= 1'b1;
                        fcnt_q       <= mk_first ? CNT_W'(1) : fcnt_q + CNT_W'(1);
                    end
                end
                ST_READ: if (mem_ack) begin
                    if (mem_err) derr_q <= 1'b1;
                    else         data_q <= mem_rdata;
                end
                ST_PUSH: ;
                ST_WBACK: if (mem_ack) begin
                    if (mem_err || fail_any || mk_last) frame_open_q <= 1'b0;
                end
                ST_NEXT: begin
                    cur_q <= next_desc;
                    idx_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign cur_load = (state_q == ST_CHECK) && (state_d == ST_READ);
    assign cur_step = (state_q == ST_PUSH) && out_ready;

    dwalk_cursor #(.AW(AW), .SIZE_W(SIZE_W)) u_cursor (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cur_load),
        .step  (cur_step),
        .dec   (link_q[LK_DEC]),
        .base  (buf_q[AW-1:0]),
        .size  (fc_q[SIZE_W-1:0]),
        .ptr   (buf_ptr),
        .last  (buf_last)
    );

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        set_eof   = 1'b0;
        set_perr  = 1'b0;
        set_derr  = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'({idx_q, {BYTE_SH{1'b0}}});
                set_derr = mem_ack && mem_err;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = buf_ptr;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = wb_word;
                set_derr  = mem_ack && (mem_err || derr_q);
                set_perr  = mem_ack && !mem_err && perr_q;
                set_eof   = mem_ack && !mem_err && !fail_any && mk_last && link_q[LK_EOFIE];
            end
            default: ;
        endcase
    end

    assign out_valid = (state_q == ST_PUSH);
    assign out_data  = data_q;
    assign busy      = (state_q != ST_IDLE);
    assign cur_addr  = cur_q;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_stream_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_cur_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur_addr[ALIGN_W-1:0] == '0));

    assert_eof_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_eof |-> (mem_ack && mem_we && !mem_err));
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker import dwalk_pkg::*; #(
    parameter int AW     = WORD_W,
    parameter int DW     = WORD_W,
    parameter int SIZE_W = FC_SIZE_W,
    parameter int CNT_W  = FC_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_err,
    output logic              out_valid,
    output logic [DW-1:0]     out_data,
    input  logic              out_ready,
    output logic              irq
);
    logic          start, cont, chain, busy;
    logic          set_eof, set_perr, set_derr;
    logic [AW-1:0] first_addr, cur_addr;

    dwalk_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .cur_addr   (cur_addr),
        .set_eof    (set_eof),
        .set_perr   (set_perr),
        .set_derr   (set_derr),
        .start      (start),
        .cont       (cont),
        .chain      (chain),
        .first_addr (first_addr),
        .irq        (irq)
    );

    dwalk_seq #(.AW(AW), .DW(DW), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cont       (cont),
        .chain      (chain),
        .first_addr (first_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_err    (mem_err),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready),
        .busy       (busy),
        .cur_addr   (cur_addr),
        .set_eof    (set_eof),
        .set_perr   (set_perr),
        .set_derr   (set_derr)
    );
endmodule

// File: tb/dma_chain_walker_tb_top.sv
`timescale 1ns/1ps
module dma_chain_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;
    logic        irq;

    always #4 clk = ~clk;

    dma_chain_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mem [0:255];
    int lat = 0;
    int wcnt = 0;
    int rp_mode = 0;
    int cyc = 0;
    logic [31:0] cap [0:1023];
    int ncap = 0;
    logic [31:0] rlog [0:1023];
    int nlog = 0;
    int viol = 0;
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h0001_9E37) ^ 32'h5A5A_0000;
    endfunction

    // memory model: in range below 0x400, error response above
    always @(posedge clk) begin
        if (prev_wait && !(mem_req && mem_addr == prev_addr)) viol = viol + 1;
        prev_wait = mem_req && !mem_ack;
        prev_addr = mem_addr;
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req && rst_n) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                mem_ack <= 1'b1;
                if (mem_addr >= 32'h400) begin
                    mem_err <= 1'b1;
                end else begin
                    mem_err <= 1'b0;
                    if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
                    else begin
                        mem_rdata <= mem[mem_addr[9:2]];
                        if (nlog < 1024) begin rlog[nlog] = mem_addr; nlog = nlog + 1; end
                    end
                end
            end else wcnt = wcnt + 1;
        end
    end

    always @(posedge clk) begin
        if (out_valid && out_ready && ncap < 1024) begin
            cap[ncap] = out_data;
            ncap = ncap + 1;
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        out_ready = (rp_mode == 0) ? 1'b1 : cyc[0];
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run(input logic [31:0] ctl);
        logic [31:0] d;
        wr(2'd0, ctl);
        for (int i = 0; i < 4000; i++) begin
            rd(2'd0, d);
            if (!d[31]) break;
        end
    endtask

    task automatic put_desc(input logic [31:0] at, input logic own, input logic [15:0] size,
                            input logic [31:0] bufa, input logic [31:0] nxt,
                            input logic dec, input logic eofie, input logic [1:0] mk);
        mem[at[9:2]]     = {own, 9'b0, 6'h15, size};
        mem[at[9:2] + 1] = 32'h0;
        mem[at[9:2] + 2] = bufa;
        mem[at[9:2] + 3] = {nxt[31:4], eofie, dec, mk};
    endtask

    function automatic logic [31:0] wb(input logic [15:0] size, input logic derr,
                                       input logic perr, input logic [5:0] cnt);
        return {1'b0, derr, perr, 7'b0, cnt, size};
    endfunction

    localparam logic [31:0] C_START = 32'h8000_0000;
    localparam logic [31:0] C_CONT  = 32'h4000_0000;
    localparam logic [31:0] C_CHAIN = 32'h2000_0000;
    localparam logic [31:0] C_IEF   = 32'h0002_0000;
    localparam logic [31:0] C_IEP   = 32'h0001_0000;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_w [0:4];
        int base, lbase;
        for (int i = 0; i < 256; i++) mem[i] = pat(32'(i) << 2);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ctrl", reg_rdata, 32'h0);
        chk("R1", "irq/req/valid", {29'b0, irq, mem_req, out_valid}, 32'h0);
        rst_n = 1'b1;
        rd(2'd3, d); chk("R1", "status", d, 32'h0);
        rd(2'd2, d); chk("R1", "current", d, 32'h0);
        rd(2'd1, d); chk("R1", "first", d, 32'h0);

        // R2 R3 R4 R5 R8: single-descriptor frame, 12 bytes
        put_desc(32'h040, 1'b1, 16'd12, 32'h300, 32'h050, 1'b0, 1'b1, 2'b11);
        for (int k = 0; k < 4; k++) mem[(32'h050 >> 2) + k] = 32'h0;
        wr(2'd1, 32'h0000_0047);
        rd(2'd1, d); chk("R2", "first readback", d, 32'h47);
        base = ncap; lbase = nlog;
        run(C_START);
        for (int k = 0; k < 4; k++) chk("R2", "fetch order", rlog[lbase + k], 32'h040 + 32'(k * 4));
        chk("R3", "word count", 32'(ncap - base), 32'd3);
        for (int k = 0; k < 3; k++) chk("R3", "stream word", cap[base + k], pat(32'h300 + 32'(k * 4)));
        chk("R4", "writeback", mem[32'h040 >> 2], wb(16'd12, 1'b0, 1'b0, 6'd1));
        rd(2'd3, d); chk("R8", "eof status", d, 32'h0800_0000);
        chk("R11", "irq on eof", {31'b0, irq}, 32'h1);
        wr(2'd3, 32'h0800_0000);
        rd(2'd3, d); chk("R11", "w1c clear", d, 32'h0);
        chk("R11", "irq cleared", {31'b0, irq}, 32'h0);

        // R3 R5 R6: three-descriptor frame swept over latency, back-pressure, direction
        for (int li = 0; li < 3; li++) begin
            for (int rp = 0; rp < 2; rp++) begin
                for (int dr = 0; dr < 2; dr++) begin
                    lat = li; rp_mode = rp;
                    put_desc(32'h100, 1'b1, 16'd5, 32'h200, 32'h110, 1'b0, 1'b0, 2'b10);
                    put_desc(32'h110, 1'b1, 16'd8, 32'h240, 32'h120, dr[0], 1'b0, 2'b00);
                    put_desc(32'h120, 1'b1, 16'd4, 32'h280, 32'h130, 1'b0, 1'b1, 2'b01);
                    for (int k = 0; k < 4; k++) mem[(32'h130 >> 2) + k] = 32'h0;
                    exp_w[0] = pat(32'h200); exp_w[1] = pat(32'h204);
                    exp_w[2] = pat(32'h240);
                    exp_w[3] = dr[0] ? pat(32'h23C) : pat(32'h244);
                    exp_w[4] = pat(32'h280);
                    wr(2'd1, 32'h100);
                    base = ncap;
                    run(C_START | C_CHAIN);
                    chk("R3", "sweep count", 32'(ncap - base), 32'd5);
                    for (int k = 0; k < 5; k++) chk("R3", "sweep word", cap[base + k], exp_w[k]);
                    chk("R5", "middle keeps count", mem[32'h110 >> 2], wb(16'd8, 1'b0, 1'b0, 6'h15));
                    chk("R5", "first keeps count", mem[32'h100 >> 2], wb(16'd5, 1'b0, 1'b0, 6'h15));
                    chk("R5", "last gets count", mem[32'h120 >> 2], wb(16'd4, 1'b0, 1'b0, 6'd3));
                    rd(2'd2, d); chk("R7", "parked at unowned", d, 32'h130);
                    rd(2'd3, d); chk("R8", "sweep eof", d, 32'h0800_0000);
                    wr(2'd3, 32'hFFFF_FFFF);
                end
            end
        end
        lat = 1; rp_mode = 0;

        // R7 R5: stall in mid-frame, then continue
        put_desc(32'h140, 1'b1, 16'd4, 32'h300, 32'h150, 1'b0, 1'b0, 2'b10);
        put_desc(32'h150, 1'b0, 16'd4, 32'h304, 32'h160, 1'b0, 1'b1, 2'b01);
        for (int k = 0; k < 4; k++) mem[(32'h160 >> 2) + k] = 32'h0;
        wr(2'd1, 32'h140);
        base = ncap;
        run(C_START | C_CHAIN);
        rd(2'd2, d); chk("R7", "current at stall", d, 32'h150);
        chk("R7", "no data for unowned", 32'(ncap - base), 32'd1);
        chk("R7", "unowned untouched", mem[32'h150 >> 2], {1'b0, 9'b0, 6'h15, 16'd4});
        rd(2'd3, d); chk("R8", "no eof yet", d, 32'h0);
        mem[32'h150 >> 2] = {1'b1, 9'b0, 6'h15, 16'd4};
        run(C_CONT | C_CHAIN);
        chk("R7", "continue moves data", 32'(ncap - base), 32'd2);
        chk("R7", "resumed word", cap[base + 1], pat(32'h304));
        chk("R5", "count across stall", mem[32'h150 >> 2], wb(16'd4, 1'b0, 1'b0, 6'd2));
        rd(2'd3, d); chk("R8", "eof after continue", d, 32'h0800_0000);
        wr(2'd3, 32'hFFFF_FFFF);

        // R9: zero size
        put_desc(32'h180, 1'b1, 16'd0, 32'h300, 32'h190, 1'b0, 1'b1, 2'b11);
        wr(2'd1, 32'h180);
        base = ncap;
        run(C_START | C_CHAIN | C_IEF);
        chk("R9", "zero size writeback", mem[32'h180 >> 2], wb(16'd0, 1'b1, 1'b0, 6'h15));
        rd(2'd3, d); chk("R9", "zero size status", d, 32'h4000_0000);
        rd(2'd2, d); chk("R9", "stopped at descriptor", d, 32'h180);
        chk("R9", "no data", 32'(ncap - base), 32'd0);
        chk("R11", "irq fail enabled", {31'b0, irq}, 32'h1);
        wr(2'd3, 32'h4000_0000);
        chk("R11", "irq fail cleared", {31'b0, irq}, 32'h0);

        // R9: bus error on buffer read
        put_desc(32'h190, 1'b1, 16'd8, 32'h800, 32'h1A0, 1'b0, 1'b1, 2'b11);
        wr(2'd1, 32'h190);
        base = ncap;
        run(C_START | C_CHAIN);
        chk("R9", "bus error writeback", mem[32'h190 >> 2], wb(16'd8, 1'b1, 1'b0, 6'h15));
        rd(2'd3, d); chk("R9", "bus error status", d, 32'h4000_0000);
        chk("R11", "irq fail masked", {31'b0, irq}, 32'h0);
        chk("R9", "bus error no data", 32'(ncap - base), 32'd0);
        wr(2'd3, 32'hFFFF_FFFF);

        // R10: frame not opened by a first marker
        put_desc(32'h1A0, 1'b1, 16'd4, 32'h300, 32'h1B0, 1'b0, 1'b1, 2'b00);
        wr(2'd1, 32'h1A0);
        base = ncap;
        run(C_START | C_CHAIN);
        chk("R10", "protocol writeback", mem[32'h1A0 >> 2], wb(16'd4, 1'b0, 1'b1, 6'h15));
        rd(2'd3, d); chk("R10", "protocol status", d, 32'h2000_0000);
        chk("R10", "protocol no data", 32'(ncap - base), 32'd0);
        chk("R11", "irq perr masked", {31'b0, irq}, 32'h0);
        wr(2'd0, C_IEP);
        chk("R11", "irq perr enabled", {31'b0, irq}, 32'h1);
        wr(2'd3, 32'hFFFF_FFFF);

        // R6: chain mode off stops after one descriptor at the link target
        put_desc(32'h1B0, 1'b1, 16'd4, 32'h308, 32'h1C0, 1'b0, 1'b1, 2'b11);
        put_desc(32'h1C0, 1'b1, 16'd4, 32'h30C, 32'h1D0, 1'b0, 1'b1, 2'b11);
        wr(2'd1, 32'h1B0);
        base = ncap;
        run(C_START);
        rd(2'd2, d); chk("R6", "current at next link", d, 32'h1C0);
        chk("R6", "one descriptor only", 32'(ncap - base), 32'd1);
        chk("R6", "next still owned", mem[32'h1C0 >> 2], {1'b1, 9'b0, 6'h15, 16'd4});
        wr(2'd3, 32'hFFFF_FFFF);

        // R8: last descriptor without interrupt enable
        put_desc(32'h1D0, 1'b1, 16'd4, 32'h310, 32'h1E0, 1'b0, 1'b0, 2'b11);
        wr(2'd1, 32'h1D0);
        run(C_START);
        rd(2'd3, d); chk("R8", "no eof without enable", d, 32'h0);
        chk("R5", "count without enable", mem[32'h1D0 >> 2], wb(16'd4, 1'b0, 1'b0, 6'd1));

        chk("R12", "request stability", 32'(viol), 32'd0);
        summary();
        $finish;
    end
endmodule